// File: doc/BRIEF.md
# Fixed-Point Color Interpolation Datapath

This block blends a three-channel fixed-point vector toward a programmable far color, or adds a scaled vector onto a previous accumulator. Each channel is worked in parallel: a first pipeline stage forms the base value and the multiplier operand, and a second stage multiplies by a 4.12 factor, adds the base, optionally drops the twelve fraction bits and produces three views of the result. These are a 32-bit accumulator, a 16-bit clamped component and an 8-bit color byte.

In the two blend modes the operand is the distance from the input to the far color. That distance is limited to the signed 16-bit range before it is scaled, and this inner limit never applies the caller's lower-limit choice. The input can be a signed 16-bit component or an unsigned 8-bit color channel with four fraction bits. In accumulate mode the operand is the component itself and the base is the previous accumulator. One operation may enter per cycle. Results appear two cycles later with a one-cycle valid pulse and hold until the next result.

Top module: `color_interp_dp`

## Requirements
- R1: An operation presented with `valid_i` high at a rising edge yields `valid_o` high for exactly one cycle, after the second rising edge that follows.
- R2: Outputs keep their value in every cycle in which no new result completes.
- R3: With `mode_i` = 00 (vector blend), base = comp·2^12, diff = far·2^12 − base, and the result = base + factor·clampdiff. When `sf_i` = 1, diff and result are each shifted right arithmetically by 12.
- R4: The blend operand clampdiff is diff limited to [−32768, 32767] after its shift, whatever the value of `lm_i`.
- R5: With `mode_i` = 01 (color blend), base = channel·2^16, where the channel is the unsigned byte of `rgbc_i` (R in bits 7:0, G 15:8, B 23:16). Otherwise the rules of R3 and R4 apply.
- R6: With `mode_i` = 10 or 11 (accumulate), result = prev·2^12 + factor·comp, shifted right by 12 when `sf_i` = 1. The far color is not used.
- R7: With `sf_i` = 0 no right shift is applied at either point.
- R8: `ir_o` per channel is the result clamped to [0, 32767] when `lm_i` = 1 and to [−32768, 32767] when `lm_i` = 0. `mac_o` per channel is the low 32 bits of the result.
- R9: `rgb_o` holds per channel (result >>> 4) clamped to [0, 255], with R in bits 7:0, G in 15:8 and B in 23:16. Bits 31:24 carry bits 31:24 of `rgbc_i` from the same operation.
- R10: After reset, `valid_o`, `mac_o`, `ir_o` and `rgb_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| mode_i | input | 2 | 00 vector blend, 01 color blend, 1x accumulate |
| sf_i | input | 1 | Drop 12 fraction bits when set |
| lm_i | input | 1 | Output component lower limit at zero when set |
| factor_i | input | 16 | Signed 4.12 factor (0x1000 = 1.0) |
| vec_i | input | 48 | Three signed 16-bit components, channel 0 in bits 15:0 |
| rgbc_i | input | 32 | Color bytes R, G, B in bits 23:0 and code byte in 31:24 |
| far_i | input | 96 | Three signed 32-bit far color values, channel 0 in bits 31:0 |
| prev_i | input | 96 | Three signed 32-bit previous accumulators |
| valid_o | output | 1 | Result pulse |
| mac_o | output | 96 | Three 32-bit accumulator results |
| ir_o | output | 48 | Three clamped 16-bit components |
| rgb_o | output | 32 | Packed color bytes with code byte |

## Verification
The hardest case to reach is an inner clamp that bites while the outer lower limit is active. It only shows when the far color lies more than 32767 units from the input after the shift, and the scaled result then has to land on the far side of zero. The stimulus sets the components at the 16-bit extremes with far values of ±40000 and a factor of 1.0. With `lm_i` set, the result is −1 and clamps to 0. A design that applied the lower limit inside would give 32767 instead. Random operations across every mode, shift and limit setting are then compared with a reference model in the bench.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int CH       = 3;
  localparam int COMP_W   = 16;
  localparam int MAC_W    = 32;
  localparam int FRAC     = 12;
  localparam int COL_W    = 8;
  localparam int COL_FRAC = 4;
  localparam int ACC_W    = MAC_W + FRAC + 4;

  typedef enum logic [1:0] {
    MODE_VEC  = 2'b00,
    MODE_COL  = 2'b01,
    MODE_ACC  = 2'b10,
    MODE_ACC2 = 2'b11
  } cip_mode_e;
endpackage

// File: rtl/cip_diff_stage.sv
module cip_diff_stage #(
  parameter int COMP_W   = cip_pkg::COMP_W,
  parameter int MAC_W    = cip_pkg::MAC_W,
  parameter int FRAC     = cip_pkg::FRAC,
  parameter int COL_W    = cip_pkg::COL_W,
  parameter int COL_FRAC = cip_pkg::COL_FRAC,
  parameter int ACC_W    = cip_pkg::ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [1:0]              mode,
  input  logic                    sf,
  input  logic [COMP_W-1:0]       comp,
  input  logic [COL_W-1:0]        col,
  input  logic [MAC_W-1:0]        far,
  input  logic [MAC_W-1:0]        prev,
  output logic [ACC_W-1:0]        base_q,
  output logic [COMP_W-1:0]       oper_q
);
  localparam longint SMAX_L = (longint'(1) << (COMP_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] S_MAX = ACC_W'(SMAX_L);
  localparam logic signed [ACC_W-1:0] S_MIN = ACC_W'(-SMAX_L - 1);
  localparam int COL_SH = FRAC + COL_FRAC;

  function automatic logic [COMP_W-1:0] sat_comp(input logic signed [ACC_W-1:0] v);
    if (v > S_MAX)      sat_comp = S_MAX[COMP_W-1:0];
    else if (v < S_MIN) sat_comp = S_MIN[COMP_W-1:0];
    else                sat_comp = v[COMP_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] comp_x, far_x, prev_x, col_x;
  logic signed [ACC_W-1:0] base_d, diff, diff_sh;
  logic        [COMP_W-1:0] oper_d;
  logic is_acc, is_col;

  always_comb begin
    comp_x = $signed({{(ACC_W-COMP_W){comp[COMP_W-1]}}, comp});
    far_x  = $signed({{(ACC_W-MAC_W){far[MAC_W-1]}}, far});
    prev_x = $signed({{(ACC_W-MAC_W){prev[MAC_W-1]}}, prev});
    col_x  = $signed({{(ACC_W-COL_W){1'b0}}, col});
    is_acc = mode[1];
    is_col = !mode[1] && mode[0];
    if (is_acc)      base_d = prev_x <<< FRAC;
    else if (is_col) base_d = col_x <<< COL_SH;
    else             base_d = comp_x <<< FRAC;
    diff    = (far_x <<< FRAC) - base_d;
    diff_sh = sf ? (diff >>> FRAC) : diff;
    oper_d  = is_acc ? comp : sat_comp(diff_sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      oper_q <= '0;
    end else if (en) begin
      base_q <= base_d;
      oper_q <= oper_d;
    end
  end
endmodule

// File: rtl/cip_blend_stage.sv
module cip_blend_stage #(
  parameter int COMP_W   = cip_pkg::COMP_W,
  parameter int MAC_W    = cip_pkg::MAC_W,
  parameter int FRAC     = cip_pkg::FRAC,
  parameter int COL_W    = cip_pkg::COL_W,
  parameter int COL_FRAC = cip_pkg::COL_FRAC,
  parameter int ACC_W    = cip_pkg::ACC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               sf,
  input  logic               lm,
  input  logic [COMP_W-1:0]  fac,
  input  logic [ACC_W-1:0]   base,
  input  logic [COMP_W-1:0]  oper,
  output logic [MAC_W-1:0]   mac_q,
  output logic [COMP_W-1:0]  ir_q,
  output logic [COL_W-1:0]   byte_q
);
  localparam longint SMAX_L = (longint'(1) << (COMP_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] S_MAX = ACC_W'(SMAX_L);
  localparam logic signed [ACC_W-1:0] S_MIN = ACC_W'(-SMAX_L - 1);
  localparam logic signed [ACC_W-1:0] C_MAX = ACC_W'((longint'(1) << COL_W) - 1);

  function automatic logic [COMP_W-1:0] sat_ir(input logic signed [ACC_W-1:0] v,
                                               input logic lo0);
    if (v > S_MAX)                     sat_ir = S_MAX[COMP_W-1:0];
    else if (lo0 && v < 0)             sat_ir = '0;
    else if (!lo0 && v < S_MIN)        sat_ir = S_MIN[COMP_W-1:0];
    else                               sat_ir = v[COMP_W-1:0];
  endfunction

  function automatic logic [COL_W-1:0] sat_col(input logic signed [ACC_W-1:0] v);
    if (v > C_MAX)  sat_col = C_MAX[COL_W-1:0];
    else if (v < 0) sat_col = '0;
    else            sat_col = v[COL_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] fac_x, oper_x, prod, sum, res, col_full;
  logic [MAC_W-1:0]  mac_d;
  logic [COMP_W-1:0] ir_d;
  logic [COL_W-1:0]  byte_d;
  logic              lm_q;

  always_comb begin
    fac_x    = $signed({{(ACC_W-COMP_W){fac[COMP_W-1]}}, fac});
    oper_x   = $signed({{(ACC_W-COMP_W){oper[COMP_W-1]}}, oper});
    prod     = fac_x * oper_x;
    sum      = $signed(base) + prod;
    res      = sf ? (sum >>> FRAC) : sum;
    col_full = res >>> COL_FRAC;
    mac_d    = res[MAC_W-1:0];
    ir_d     = sat_ir(res, lm);
    byte_d   = sat_col(col_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q  <= '0;
      ir_q   <= '0;
      byte_q <= '0;
      lm_q   <= 1'b0;
    end else if (en) begin
      mac_q  <= mac_d;
      ir_q   <= ir_d;
      byte_q <= byte_d;
      lm_q   <= lm;
    end
  end

  // R8
  ir_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_q |-> !ir_q[COMP_W-1]);

  // R9
  byte_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lm_q && ir_q[COMP_W-1]) |-> (byte_q == '0));
endmodule

// File: rtl/color_interp_dp.sv
module color_interp_dp #(
  parameter int CH       = cip_pkg::CH,
  parameter int COMP_W   = cip_pkg::COMP_W,
  parameter int MAC_W    = cip_pkg::MAC_W,
  parameter int FRAC     = cip_pkg::FRAC,
  parameter int COL_W    = cip_pkg::COL_W,
  parameter int COL_FRAC = cip_pkg::COL_FRAC,
  parameter int ACC_W    = cip_pkg::ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_i,
  input  logic [1:0]              mode_i,
  input  logic                    sf_i,
  input  logic                    lm_i,
  input  logic [COMP_W-1:0]       factor_i,
  input  logic [CH*COMP_W-1:0]    vec_i,
  input  logic [(CH+1)*COL_W-1:0] rgbc_i,
  input  logic [CH*MAC_W-1:0]     far_i,
  input  logic [CH*MAC_W-1:0]     prev_i,
  output logic                    valid_o,
  output logic [CH*MAC_W-1:0]     mac_o,
  output logic [CH*COMP_W-1:0]    ir_o,
  output logic [(CH+1)*COL_W-1:0] rgb_o
);
  localparam int CODE_LSB = CH * COL_W;

  logic              v1_d, v2_d, sf1_d, lm1_d;
  logic              v1_q, v2_q, sf1_q, lm1_q;
  logic [COMP_W-1:0] fac1_d, fac1_q;
  logic [COL_W-1:0]  code1_d, code2_d, code1_q, code2_q;
  logic [CH*COL_W-1:0] bytes;

  always_comb begin
    v1_d    = valid_i;
    v2_d    = v1_q;
    sf1_d   = sf_i;
    lm1_d   = lm_i;
    fac1_d  = factor_i;
    code1_d = rgbc_i[CODE_LSB +: COL_W];
    code2_d = code1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf1_q   <= 1'b0;
      lm1_q   <= 1'b0;
      fac1_q  <= '0;
      code1_q <= '0;
    end else if (valid_i) begin
      sf1_q   <= sf1_d;
      lm1_q   <= lm1_d;
      fac1_q  <= fac1_d;
      code1_q <= code1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code2_q <= '0;
    else if (v1_q) code2_q <= code2_d;
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [ACC_W-1:0]  base_q;
    logic [COMP_W-1:0] oper_q;

    cip_diff_stage #(
      .COMP_W(COMP_W), .MAC_W(MAC_W), .FRAC(FRAC),
      .COL_W(COL_W), .COL_FRAC(COL_FRAC), .ACC_W(ACC_W)
    ) diff_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (valid_i),
      .mode   (mode_i),
      .sf     (sf_i),
      .comp   (vec_i[c*COMP_W +: COMP_W]),
      .col    (rgbc_i[c*COL_W +: COL_W]),
      .far    (far_i[c*MAC_W +: MAC_W]),
      .prev   (prev_i[c*MAC_W +: MAC_W]),
      .base_q (base_q),
      .oper_q (oper_q)
    );

    cip_blend_stage #(
      .COMP_W(COMP_W), .MAC_W(MAC_W), .FRAC(FRAC),
      .COL_W(COL_W), .COL_FRAC(COL_FRAC), .ACC_W(ACC_W)
    ) blend_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (v1_q),
      .sf     (sf1_q),
      .lm     (lm1_q),
      .fac    (fac1_q),
      .base   (base_q),
      .oper   (oper_q),
      .mac_q  (mac_o[c*MAC_W +: MAC_W]),
      .ir_q   (ir_o[c*COMP_W +: COMP_W]),
      .byte_q (bytes[c*COL_W +: COL_W])
    );
  end

  assign valid_o = v2_q;
  assign rgb_o   = {code2_q, bytes};

  // R1
  lat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> ##2 valid_o);

  // R1
  lat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> ##2 !valid_o);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> ##2 ($stable(mac_o) && $stable(ir_o) && $stable(rgb_o)));

  // R9
  code_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> ##2 (rgb_o[CODE_LSB +: COL_W] == $past(rgbc_i[CODE_LSB +: COL_W], 2)));
endmodule

// File: tb/color_interp_dp_tb_top.sv
`timescale 1ns/1ps
module color_interp_dp_tb_top;
  logic        clk, rst_n, valid_i, sf_i, lm_i;
  logic [1:0]  mode_i;
  logic [15:0] factor_i;
  logic [47:0] vec_i;
  logic [31:0] rgbc_i;
  logic [95:0] far_i, prev_i;
  logic        valid_o;
  logic [95:0] mac_o;
  logic [47:0] ir_o;
  logic [31:0] rgb_o;

  int checks = 0;
  int errors = 0;

  color_interp_dp dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .sf_i(sf_i), .lm_i(lm_i), .factor_i(factor_i), .vec_i(vec_i),
    .rgbc_i(rgbc_i), .far_i(far_i), .prev_i(prev_i), .valid_o(valid_o),
    .mac_o(mac_o), .ir_o(ir_o), .rgb_o(rgb_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model(input int mode, input bit sf, input longint comp,
                                   input longint col, input longint far,
                                   input longint prev, input longint fac);
    longint base, d, s;
    if (mode >= 2)      base = prev * 4096;
    else if (mode == 1) base = col * 65536;
    else                base = comp * 4096;
    if (mode >= 2) d = comp;
    else begin
      d = far * 4096 - base;
      if (sf) d = d >>> 12;
      if (d > 32767) d = 32767;
      if (d < -32768) d = -32768;
    end
    s = base + fac * d;
    if (sf) s = s >>> 12;
    return s;
  endfunction

  function automatic longint clampl(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // Drive one operation and return at the falling edge after its result lands.
  task automatic issue(input int mode, input bit sf, input bit lm, input int fac);
    @(negedge clk);
    mode_i = 2'(mode); sf_i = sf; lm_i = lm; factor_i = 16'(fac);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
  endtask

  // Compare all outputs with the reference model for the inputs now applied.
  task automatic compare_model(input string req);
    for (int c = 0; c < 3; c++) begin
      longint s;
      s = model(int'(mode_i), sf_i,
                longint'($signed(vec_i[c*16 +: 16])),
                longint'(rgbc_i[c*8 +: 8]),
                longint'($signed(far_i[c*32 +: 32])),
                longint'($signed(prev_i[c*32 +: 32])),
                longint'($signed(factor_i)));
      chk({req, " mac"}, longint'(mac_o[c*32 +: 32]), longint'(s[31:0]));
      chk({req, " ir"}, longint'($signed(ir_o[c*16 +: 16])),
          clampl(s, lm_i ? 0 : -32768, 32767));
      chk({req, " byte"}, longint'(rgb_o[c*8 +: 8]), clampl(s >>> 4, 0, 255));
    end
    chk({req, " code"}, longint'(rgb_o[31:24]), longint'(rgbc_i[31:24]));
  endtask

  task automatic set_vec(input int a, input int b, input int d);
    vec_i = {16'(d), 16'(b), 16'(a)};
  endtask
  task automatic set_far(input int a, input int b, input int d);
    far_i = {32'(d), 32'(b), 32'(a)};
  endtask
  task automatic set_prev(input int a, input int b, input int d);
    prev_i = {32'(d), 32'(b), 32'(a)};
  endtask

  task automatic t_reset;
    chk("R10 valid", longint'(valid_o), 0);
    chk("R10 mac", longint'(mac_o == '0), 1);
    chk("R10 ir", longint'(ir_o == '0), 1);
    chk("R10 rgb", longint'(rgb_o == '0), 1);
  endtask

  task automatic t_vec_half;
    set_vec(16'h1000, 16'h1000, 16'h1000); set_far(0, 0, 0); set_prev(0, 0, 0);
    rgbc_i = 32'h0;
    issue(0, 1'b1, 1'b0, 16'h0800);
    chk("R1 valid", longint'(valid_o), 1);
    for (int c = 0; c < 3; c++) begin
      chk("R3 mac", longint'($signed(mac_o[c*32 +: 32])), 2048);
      chk("R8 ir", longint'($signed(ir_o[c*16 +: 16])), 2048);
      chk("R9 byte", longint'(rgb_o[c*8 +: 8]), 128);
    end
    @(negedge clk);
    chk("R1 pulse", longint'(valid_o), 0);
    repeat (3) @(negedge clk);
    chk("R2 hold", longint'($signed(mac_o[31:0])), 2048);
  endtask

  task automatic t_color_half;
    rgbc_i = 32'h5AFFFFFF; set_far(0, 0, 0);
    issue(1, 1'b1, 1'b0, 16'h0800);
    for (int c = 0; c < 3; c++) begin
      chk("R5 mac", longint'($signed(mac_o[c*32 +: 32])), 2040);
      chk("R9 byte", longint'(rgb_o[c*8 +: 8]), 127);
    end
    chk("R9 code", longint'(rgb_o[31:24]), 8'h5A);
  endtask

  task automatic t_accum;
    set_prev(-10000, -20000, -30000); set_vec(100, 200, 300);
    set_far(32'h7FFFFFFF, 1, -5); rgbc_i = 32'h11000000;
    issue(2, 1'b1, 1'b0, 16'h1000);
    chk("R6 mac0", longint'($signed(mac_o[31:0])), -9900);
    chk("R6 mac1", longint'($signed(mac_o[63:32])), -19800);
    chk("R6 mac2", longint'($signed(mac_o[95:64])), -29700);
    chk("R8 ir neg", longint'($signed(ir_o[15:0])), -9900);
    chk("R9 byte neg", longint'(rgb_o[7:0]), 0);
    issue(3, 1'b1, 1'b1, 16'h1000);
    chk("R6 mode3", longint'($signed(mac_o[95:64])), -29700);
    chk("R8 lm floor", longint'(ir_o[47:32]), 0);
  endtask

  task automatic t_inner_clamp;
    set_vec(32767, -32768, 0); set_far(-40000, 40000, 5); rgbc_i = 32'h0;
    issue(0, 1'b1, 1'b1, 16'h1000);
    chk("R4 mac0", longint'($signed(mac_o[31:0])), -1);
    chk("R4 mac1", longint'($signed(mac_o[63:32])), -1);
    chk("R3 mac2", longint'($signed(mac_o[95:64])), 5);
    chk("R8 ir0 lm", longint'($signed(ir_o[15:0])), 0);
    issue(0, 1'b1, 1'b0, 16'h1000);
    chk("R8 ir0 nolm", longint'($signed(ir_o[15:0])), -1);
  endtask

  task automatic t_noshift;
    set_vec(2, 2, 2); set_far(3, 3, 3); rgbc_i = 32'h0;
    issue(0, 1'b0, 1'b0, 16'h1000);
    chk("R7 mac", longint'($signed(mac_o[31:0])), 16785408);
    chk("R8 ir sat", longint'($signed(ir_o[15:0])), 32767);
    chk("R9 byte sat", longint'(rgb_o[7:0]), 255);
  endtask

  task automatic t_random;
    for (int n = 0; n < 60; n++) begin
      vec_i  = {$urandom(), $urandom()};
      rgbc_i = $urandom();
      far_i  = {$urandom(), $urandom(), $urandom()};
      prev_i = {$urandom(), $urandom(), $urandom()};
      if (n % 3 == 0) begin
        far_i  = {32'($signed(16'($urandom()))), 32'($signed(16'($urandom()))),
                  32'($signed(16'($urandom()))) };
        prev_i = {32'($signed(20'($urandom()))), 32'($signed(20'($urandom()))),
                  32'($signed(20'($urandom()))) };
      end
      issue(n % 4, 1'((n / 4) % 2), 1'((n / 8) % 2), int'(16'($urandom())));
      compare_model("R3 R5 R6 R7 R8 R9 random");
    end
  endtask

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; mode_i = 2'b00; sf_i = 1'b0; lm_i = 1'b0;
    factor_i = '0; vec_i = '0; rgbc_i = '0; far_i = '0; prev_i = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_vec_half;
    t_color_half;
    t_accum;
    t_inner_clamp;
    t_noshift;
    t_random;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule